// File: doc/BRIEF.md
# Console Transmit Register Pair

This block sits between a processor's register bus and a byte-wide console transmitter. It presents two registers: a status/control register holding a ready flag and an interrupt enable, and a write-only output byte register. When the processor writes a character into the output register, the ready flag drops, any pending interrupt request is withdrawn, and the character is offered to the transmitter over a valid/ready handshake. Once the transmitter takes the byte, the ready flag returns and an interrupt is requested if enabled.

While the transmitter holds off, the block keeps offering the same byte and the ready flag stays low. Each character passes through a conversion chosen at the moment it is written. The 8-bit mode passes it unchanged. The 7-bit mode strips the top bit. The printable mode strips the top bit and silently discards control codes other than the usual formatting ones; a discarded character still completes and sets the ready flag. The ready flag comes out of reset set, so software sees an idle port at power-up.

Top module: `ctx_console_tx`

## Requirements
- R1: The status read value carries the ready flag at bit 7 and the interrupt enable at bit 6, with every other bit zero; a status write updates only the interrupt enable from bit 6 and never changes the ready flag.
- R2: A write to the output register keeps only bits 7:0, clears the ready flag and the interrupt request in the next cycle, and starts an output operation.
- R3: When tx_valid and tx_ready are both high at a clock edge, the ready flag is set after that edge and irq follows the interrupt enable.
- R4: While tx_ready is low, tx_valid stays high with tx_data unchanged and the ready flag stays clear.
- R5: A status write with bit 6 clear drops irq. A status write with bit 6 set, made while the ready flag is set and the enable was clear, raises irq after that edge. irq is never high unless both the ready flag and the enable are set.
- R6: Synchronous reset sets the ready flag, clears the enable, irq and the held byte, and cancels any pending output (tx_valid low).
- R7: With mode_sel 2'b01 or 2'b11 (8-bit), the written byte appears on tx_data unchanged.
- R8: With mode_sel 2'b00 (7-bit), the byte appears on tx_data with bit 7 cleared.
- R9: With mode_sel 2'b10 (printable), bit 7 is cleared; the resulting codes 0x00 to 0x1F other than 0x07, 0x08, 0x09, 0x0A and 0x0D, and the code 0x7F, are never offered on tx_valid and complete one cycle after the write with the ready flag set.
- R10: mode_sel is sampled at the write. A second write before completion replaces the pending byte, and a write in the same cycle as a completion wins, leaving the ready flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Character conversion mode, sampled at each output write |
| csr_wr_en | input | 1 | Status register write strobe |
| csr_wr_data | input | REG_W | Status register write data (bit 6 is the enable) |
| csr_rd_data | output | REG_W | Status register read value |
| buf_wr_en | input | 1 | Output byte register write strobe |
| buf_wr_data | input | REG_W | Output byte write data (bits 7:0 used) |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Converted byte for the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| irq | output | 1 | Interrupt request |

## Verification
Every one of the 256 byte values is sent in each of the four mode encodings, so the bench separates the stripped, passed and discarded code sets by comparing tx_data against an arithmetic model of each mode. The stall length and the enable setting vary with the byte, which distinguishes a held offer from a repeated one and shows whether irq follows the enable at completion. Directed sequences then cover the enable-raise rule, read-only ready flag, byte replacement during a stall, a write colliding with an accept, and reset mid-transfer.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int CHAR_W   = 8;
    localparam int READY_BIT = 7;
    localparam int ENABLE_BIT = 6;

    typedef enum logic [1:0] {
        MODE_SEVEN   = 2'b00,
        MODE_EIGHT   = 2'b01,
        MODE_PRINT   = 2'b10,
        MODE_EIGHT_B = 2'b11
    } char_mode_e;

    typedef struct packed {
        logic              discard;
        logic [CHAR_W-1:0] code;
    } out_char_t;

    function automatic logic is_format_code(input logic [6:0] c);
        return (c == 7'h07) || (c == 7'h08) || (c == 7'h09) ||
               (c == 7'h0A) || (c == 7'h0D);
    endfunction

    function automatic logic is_nonprinting(input logic [6:0] c);
        return ((c < 7'h20) && !is_format_code(c)) || (c == 7'h7F);
    endfunction

endpackage

// File: rtl/ctx_char_filter.sv
module ctx_char_filter
    import ctx_pkg::*;
(
    input  logic [CHAR_W-1:0] raw_char,
    input  logic [1:0]        mode_sel,
    output out_char_t         conv_char
);

    char_mode_e        mode;
    logic [CHAR_W-1:0] stripped;

    assign mode     = char_mode_e'(mode_sel);
    assign stripped = {1'b0, raw_char[CHAR_W-2:0]};

    always_comb begin
        conv_char.discard = 1'b0;
        conv_char.code    = raw_char;
        unique case (mode)
            MODE_SEVEN: begin
                conv_char.code = stripped;
            end
            MODE_PRINT: begin
                conv_char.code    = stripped;
                conv_char.discard = is_nonprinting(stripped[6:0]);
            end
            MODE_EIGHT, MODE_EIGHT_B: begin
                conv_char.code = raw_char;
            end
            default: begin
                conv_char.code = raw_char;
            end
        endcase
    end

endmodule

// File: rtl/ctx_tx_holder.sv
module ctx_tx_holder
    import ctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  out_char_t         load_char,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              complete
);

    logic      busy;
    out_char_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            held <= '0;
        end else if (load) begin
            busy <= 1'b1;
            held <= load_char;
        end else if (complete) begin
            busy <= 1'b0;
        end
    end

    assign tx_valid = busy && !held.discard;
    assign tx_data  = held.code;
    assign complete = busy && (held.discard || tx_ready);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data))); // R4

endmodule

// File: rtl/ctx_csr_ctrl.sv
module ctx_csr_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic csr_we,
    input  logic enable_wdata,
    input  logic buf_we,
    input  logic complete,
    output logic ready,
    output logic enable,
    output logic irq
);

    logic ready_n;
    logic enable_n;
    logic irq_n;

    always_comb begin
        enable_n = csr_we ? enable_wdata : enable;
        ready_n  = ready;
        irq_n    = irq;
        if (buf_we) begin
            ready_n = 1'b0;
            irq_n   = 1'b0;
        end else if (complete) begin
            ready_n = 1'b1;
            irq_n   = enable_n;
        end
        if (csr_we) begin
            if (!enable_wdata)
                irq_n = 1'b0;
            else if (ready_n && !enable)
                irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready  <= 1'b1;
            enable <= 1'b0;
            irq    <= 1'b0;
        end else begin
            ready  <= ready_n;
            enable <= enable_n;
            irq    <= irq_n;
        end
    end

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> (!ready && !irq)); // R2

    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ready && enable)); // R5

    AST_ENABLE_RAISES: assert property (@(posedge clk) disable iff (rst)
        (csr_we && enable_wdata && ready && !enable && !buf_we) |=> irq); // R5

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !enable_wdata) |=> !irq); // R5

endmodule

// File: rtl/ctx_console_tx.sv
module ctx_console_tx
    import ctx_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              csr_wr_en,
    input  logic [REG_W-1:0]  csr_wr_data,
    output logic [REG_W-1:0]  csr_rd_data,
    input  logic              buf_wr_en,
    input  logic [REG_W-1:0]  buf_wr_data,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq
);

    out_char_t conv_char;
    logic      complete;
    logic      ready;
    logic      enable;
    logic      unused_wdata;

    assign unused_wdata = ^{csr_wr_data, buf_wr_data};

    ctx_char_filter u_filter (
        .raw_char  (buf_wr_data[CHAR_W-1:0]),
        .mode_sel  (mode_sel),
        .conv_char (conv_char)
    );

    ctx_tx_holder u_holder (
        .clk       (clk),
        .rst       (rst),
        .load      (buf_wr_en),
        .load_char (conv_char),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .complete  (complete)
    );

    ctx_csr_ctrl u_csr (
        .clk          (clk),
        .rst          (rst),
        .csr_we       (csr_wr_en),
        .enable_wdata (csr_wr_data[ENABLE_BIT]),
        .buf_we       (buf_wr_en),
        .complete     (complete),
        .ready        (ready),
        .enable       (enable),
        .irq          (irq)
    );

    always_comb begin
        csr_rd_data             = '0;
        csr_rd_data[READY_BIT]  = ready;
        csr_rd_data[ENABLE_BIT] = enable;
    end

    AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !buf_wr_en) |=> ready); // R3

    AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !buf_wr_en) |=> !ready); // R4

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready && !enable && !irq && !tx_valid)); // R6

endmodule

// File: tb/tb_ctx_console_tx.sv
module tb_ctx_console_tx;

    localparam int REG_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode_sel = 2'b01;
    logic             csr_wr_en = 1'b0;
    logic [REG_W-1:0] csr_wr_data = '0;
    logic [REG_W-1:0] csr_rd_data;
    logic             buf_wr_en = 1'b0;
    logic [REG_W-1:0] buf_wr_data = '0;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;
    logic             irq;

    int total = 0;
    int bad = 0;

    ctx_console_tx #(.REG_W(REG_W)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_csr(input logic [REG_W-1:0] v);
        csr_wr_en = 1'b1;
        csr_wr_data = v;
        tick();
        csr_wr_en = 1'b0;
        csr_wr_data = '0;
    endtask

    task automatic write_buf(input logic [REG_W-1:0] v, input logic [1:0] m);
        mode_sel = m;
        buf_wr_en = 1'b1;
        buf_wr_data = v;
        tick();
        buf_wr_en = 1'b0;
        buf_wr_data = '0;
        mode_sel = ~m;
    endtask

    function automatic logic [7:0] exp_code(input logic [7:0] b, input logic [1:0] m);
        if (m == 2'b01 || m == 2'b11) return b;
        return b % 128;
    endfunction

    function automatic bit exp_drop(input logic [7:0] b, input logic [1:0] m);
        int c;
        c = b % 128;
        if (m != 2'b10) return 1'b0;
        if (c == 127) return 1'b1;
        if (c >= 32) return 1'b0;
        return !(c == 7 || c == 8 || c == 9 || c == 10 || c == 13);
    endfunction

    task automatic send_one(input int b, input int m);
        logic [7:0] ec;
        bit en;
        int stalls;
        ec = exp_code(8'(b), 2'(m));
        en = (b % 2) == 1;
        stalls = b % 3;
        write_csr(en ? 16'h0040 : 16'h0000);
        write_buf(16'hA500 | 16'(b), 2'(m));
        check(csr_rd_data[7] == 1'b0 && irq == 1'b0, "R2", {csr_rd_data[7], irq}, 0);
        if (exp_drop(8'(b), 2'(m))) begin
            check(tx_valid == 1'b0, "R9", tx_valid, 0);
            tick();
            check(csr_rd_data[7] && !tx_valid && irq == en, "R9",
                  {csr_rd_data[7], tx_valid, irq}, {1'b1, 1'b0, en});
        end else begin
            check(tx_valid && tx_data == ec,
                  (m == 2'b00) ? "R8" : ((m == 2'b10) ? "R9" : "R7"),
                  {tx_valid, tx_data}, {1'b1, ec});
            for (int s = 0; s < stalls; s++) begin
                tick();
                check(tx_valid && tx_data == ec && !csr_rd_data[7], "R4",
                      {tx_valid, tx_data, csr_rd_data[7]}, {1'b1, ec, 1'b0});
            end
            tx_ready = 1'b1;
            tick();
            tx_ready = 1'b0;
            check(csr_rd_data[7] && !tx_valid && irq == en, "R3",
                  {csr_rd_data[7], tx_valid, irq}, {1'b1, 1'b0, en});
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        rst = 1'b0;
        check(csr_rd_data == 16'h0080 && !irq && !tx_valid, "R6",
              {csr_rd_data, irq, tx_valid}, 16'h0080 << 2);

        // R1: only the enable is writable, other bits read zero
        write_csr(16'hFFFF);
        check(csr_rd_data == 16'h00C0, "R1", csr_rd_data, 16'h00C0);
        write_csr(16'h0000);
        check(csr_rd_data == 16'h0080, "R1", csr_rd_data, 16'h0080);

        // R5: raise on enable while ready, drop on disable
        check(irq == 1'b0, "R5", irq, 0);
        write_csr(16'h0040);
        check(irq == 1'b1, "R5", irq, 1);
        write_csr(16'h0040);
        check(irq == 1'b1, "R5", irq, 1);
        write_csr(16'h0000);
        check(irq == 1'b0, "R5", irq, 0);

        // sweep every byte in every mode encoding
        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 256; b++)
                send_one(b, m);

        // R1: ready flag cannot be written while busy
        write_csr(16'h0000);
        write_buf(16'h0041, 2'b01);
        write_csr(16'h0080);
        check(csr_rd_data == 16'h0000 && !irq, "R1", csr_rd_data, 0);
        // R5: enabling while not ready does not raise irq
        write_csr(16'h0040);
        check(irq == 1'b0 && csr_rd_data == 16'h0040, "R5", {irq, csr_rd_data}, 16'h0040);

        // R10: second write during stall replaces the byte (new mode applies)
        write_buf(16'h00C2, 2'b00);
        check(tx_valid && tx_data == 8'h42, "R10", tx_data, 8'h42);
        // R10: write colliding with accept wins
        tx_ready = 1'b1;
        buf_wr_en = 1'b1;
        buf_wr_data = 16'h0033;
        mode_sel = 2'b01;
        tick();
        buf_wr_en = 1'b0;
        tx_ready = 1'b0;
        check(tx_valid && tx_data == 8'h33 && !csr_rd_data[7] && !irq, "R10",
              {tx_valid, tx_data, csr_rd_data[7]}, {1'b1, 8'h33, 1'b0});
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
        check(csr_rd_data[7] && irq, "R3", {csr_rd_data[7], irq}, 2'b11);

        // R6: reset cancels a pending output
        write_buf(16'h0055, 2'b01);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check(!tx_valid && csr_rd_data == 16'h0080 && !irq, "R6",
              {tx_valid, csr_rd_data, irq}, 16'h0080 << 1);
        check(tx_data == 8'h00, "R6", tx_data, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule